// File: doc/BRIEF.md
# Serial Synthesizer Programming Port

This block is the control port of a frequency synthesizer. Three pins come in: a serial clock, a serial data line and a latch strobe. They are sampled by the block's own system clock. Each rising edge of the serial clock moves one data bit into an 18-bit holding shift register, most-significant bit first. A rising edge on the latch strobe commits the held word. The last bit shifted, bit 0 of the word, picks the destination. A 0 loads the feedback-path register, which holds the B count, the A count and a 2-bit control word. A 1 loads the reference-path register, which holds the reference divide ratio, a charge-pump high-impedance bit, a phase-detector polarity bit, a reserved bit and a test-mode bit. Both registers are decoded into plain parallel output pins.

The three serial pins pass through a synchronizer before their edges are detected. Each level of the serial clock and of the strobe must therefore be held for at least SYNC_STAGES+2 system clocks. The pins should idle low. The interface has no back-pressure and no valid/ready handshake, because the host owns the serial clock and every bit it clocks is accepted. A reference divide value below 2 is refused. The divider keeps its previous ratio and an error pin is raised.

Top module: `synth_ctl_port`

## Requirements
- R1: After reset the feedback B, A and control outputs are all zero, the reference divide output is 2, the tristate, polarity, reserved and test outputs are 0, and the error output is 0.
- R2: A word is the last 18 bits sampled on rising serial-clock edges, with the first bit sent ending up as word bit 17. Bits sent before those 18 have no effect.
- R3: On a latch with word bit 0 = 0, the feedback register loads, and the reference outputs and the error output are unchanged.
- R4: On a latch with word bit 0 = 1, the reference register loads and the feedback outputs are unchanged.
- R5: The feedback fields decode as follows: B = word[17:8], A = word[7:3], control = word[2:1].
- R6: The reference fields decode as follows: divide = word[10:1], tristate = word[11], polarity = word[12], reserved = word[13], test = word[14]. Word bits 17..15 are ignored.
- R7: A register loads only on a rising edge of the latch strobe. Shifting while the strobe is held high or held low changes no output.
- R8: A reference latch whose divide field is 0 or 1 keeps the old divide, loads the other reference bits and sets the error output. The error output stays set through feedback loads and clears on the next reference latch that carries a legal divide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Latch strobe; rising edge commits the word |
| fb_b_count | output | 10 | Feedback B counter value |
| fb_a_count | output | 5 | Feedback A counter value |
| fb_ctrl | output | 2 | Feedback control word |
| ref_div | output | 10 | Reference divide ratio, never below 2 |
| cp_tristate | output | 1 | Charge pump high-impedance control |
| pd_polarity | output | 1 | Phase detector polarity |
| ref_reserved | output | 1 | Reserved reference bit as written |
| test_mode | output | 1 | Test mode enable |
| div_error | output | 1 | Last reference latch carried an illegal divide |

## Verification
The bench sweeps the reference divide field through 0..63, while the four control bits and the ignored bits vary with it. A design that compared against the wrong bound, or decoded off by one bit, would show a wrong ratio or a missing error at divides 0, 1 and 2. A walking one across all 17 data bits of a feedback word catches any swapped or shifted field boundary. A flipped address test would show up as an output of the wrong register moving. Words preceded by junk bits, and words shifted while the strobe is held high, target a design that counts bits instead of keeping the last 18, or that loads on the strobe level rather than on its edge. Feedback loads made while the error is set show whether the error is cleared by the wrong path.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
  localparam int WORD_W  = 18;
  localparam int DATA_W  = WORD_W - 1;
  localparam int B_W     = 10;
  localparam int A_W     = 5;
  localparam int CTL_W   = 2;
  localparam int RDIV_W  = 10;

  localparam int CTL_LSB = 0;
  localparam int A_LSB   = CTL_LSB + CTL_W;
  localparam int B_LSB   = A_LSB + A_W;

  localparam int CPOFF_BIT = RDIV_W;
  localparam int POL_BIT   = RDIV_W + 1;
  localparam int RSV_BIT   = RDIV_W + 2;
  localparam int TEST_BIT  = RDIV_W + 3;

  typedef struct packed {
    logic [B_W-1:0]   b_cnt;
    logic [A_W-1:0]   a_cnt;
    logic [CTL_W-1:0] ctl;
  } fb_cfg_t;

  typedef struct packed {
    logic              test;
    logic              rsvd;
    logic              pol;
    logic              cp_off;
    logic [RDIV_W-1:0] div;
  } ref_cfg_t;
endpackage

// File: rtl/synth_ctl_sync.sv
module synth_ctl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= async_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/synth_ctl_edge.sv
module synth_ctl_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  // R7: a detected edge lasts exactly one system clock
  p_single_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/synth_ctl_shifter.sv
module synth_ctl_shifter #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] word_o
);
  logic [WIDTH-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (shift_i) sh_q <= {sh_q[WIDTH-2:0], bit_i};
  end

  assign word_o = sh_q;

  // R2: the held word moves only on a serial clock edge
  p_hold_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_i |=> $stable(sh_q));
endmodule

// File: rtl/synth_ctl_bank.sv
module synth_ctl_bank
  import synth_ctl_pkg::*;
#(
  parameter int DIV_RESET = 2,
  parameter int DIV_MIN   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output fb_cfg_t           fb_o,
  output ref_cfg_t          ref_o,
  output logic              err_o
);
  logic              sel_ref;
  logic [DATA_W-1:0] data;
  fb_cfg_t           fb_new;
  ref_cfg_t          ref_new;
  logic              div_bad;
  fb_cfg_t           fb_q;
  ref_cfg_t          ref_q;
  logic              err_q;

  always_comb begin
    sel_ref        = word_i[0];
    data           = word_i[WORD_W-1:1];
    fb_new.b_cnt   = data[B_LSB +: B_W];
    fb_new.a_cnt   = data[A_LSB +: A_W];
    fb_new.ctl     = data[CTL_LSB +: CTL_W];
    ref_new.div    = data[0 +: RDIV_W];
    ref_new.cp_off = data[CPOFF_BIT];
    ref_new.pol    = data[POL_BIT];
    ref_new.rsvd   = data[RSV_BIT];
    ref_new.test   = data[TEST_BIT];
    div_bad        = int'(ref_new.div) < DIV_MIN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q         <= '0;
      ref_q.test   <= 1'b0;
      ref_q.rsvd   <= 1'b0;
      ref_q.pol    <= 1'b0;
      ref_q.cp_off <= 1'b0;
      ref_q.div    <= RDIV_W'(DIV_RESET);
      err_q        <= 1'b0;
    end else if (load_i) begin
      if (!sel_ref) begin
        fb_q <= fb_new;
      end else begin
        ref_q.test   <= ref_new.test;
        ref_q.rsvd   <= ref_new.rsvd;
        ref_q.pol    <= ref_new.pol;
        ref_q.cp_off <= ref_new.cp_off;
        if (div_bad) begin
          err_q <= 1'b1;
        end else begin
          ref_q.div <= ref_new.div;
          err_q     <= 1'b0;
        end
      end
    end
  end

  assign fb_o  = fb_q;
  assign ref_o = ref_q;
  assign err_o = err_q;

  // R3: a feedback load leaves the reference side alone
  p_fb_steer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !word_i[0]) |=> ($stable(ref_q) && $stable(err_q)));
  // R4: a reference load leaves the feedback side alone
  p_ref_steer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && word_i[0]) |=> $stable(fb_q));
  // R7: nothing moves without a latch edge
  p_no_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(fb_q) && $stable(ref_q) && $stable(err_q)));
  // R8: an illegal divide is refused and flagged
  p_bad_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && word_i[0] && (word_i[RDIV_W:1] < RDIV_W'(DIV_MIN)))
      |=> (err_q && $stable(ref_q.div)));
  // R8: the stored divide never drops below the floor
  p_div_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ref_q.div) >= DIV_MIN);
endmodule

// File: rtl/synth_ctl_port.sv
module synth_ctl_port
  import synth_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_RESET   = 2,
  parameter int DIV_MIN     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_latch,
  output logic [B_W-1:0]    fb_b_count,
  output logic [A_W-1:0]    fb_a_count,
  output logic [CTL_W-1:0]  fb_ctrl,
  output logic [RDIV_W-1:0] ref_div,
  output logic              cp_tristate,
  output logic              pd_polarity,
  output logic              ref_reserved,
  output logic              test_mode,
  output logic              div_error
);
  localparam int PIN_N  = 3;
  localparam int EDGE_N = 2;

  logic [PIN_N-1:0]  pins_s;
  logic [EDGE_N-1:0] rise;
  logic [WORD_W-1:0] word;
  fb_cfg_t           fb;
  ref_cfg_t          rc;

  synth_ctl_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({ser_latch, ser_data, ser_clk}),
    .sync_o(pins_s)
  );

  synth_ctl_edge #(.W(EDGE_N)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl_i({pins_s[2], pins_s[0]}),
    .rise_o(rise)
  );

  synth_ctl_shifter #(.WIDTH(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_i(rise[0]),
    .bit_i(pins_s[1]),
    .word_o(word)
  );

  synth_ctl_bank #(.DIV_RESET(DIV_RESET), .DIV_MIN(DIV_MIN)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .load_i(rise[1]),
    .word_i(word),
    .fb_o(fb),
    .ref_o(rc),
    .err_o(div_error)
  );

  assign fb_b_count   = fb.b_cnt;
  assign fb_a_count   = fb.a_cnt;
  assign fb_ctrl      = fb.ctl;
  assign ref_div      = rc.div;
  assign cp_tristate  = rc.cp_off;
  assign pd_polarity  = rc.pol;
  assign ref_reserved = rc.rsvd;
  assign test_mode    = rc.test;
endmodule

// File: tb/test_synth_ctl_port.sv
module test_synth_ctl_port;
  localparam int HP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_latch = 1'b0;
  logic [9:0] fb_b_count, ref_div;
  logic [4:0] fb_a_count;
  logic [1:0] fb_ctrl;
  logic cp_tristate, pd_polarity, ref_reserved, test_mode, div_error;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [9:0] e_b, e_div;
  logic [4:0] e_a;
  logic [1:0] e_ctl;
  logic e_off, e_pol, e_rsv, e_test, e_err;

  always #5 clk = ~clk;

  synth_ctl_port i_synth_ctl_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_latch(ser_latch), .fb_b_count(fb_b_count), .fb_a_count(fb_a_count),
    .fb_ctrl(fb_ctrl), .ref_div(ref_div), .cp_tristate(cp_tristate),
    .pd_polarity(pd_polarity), .ref_reserved(ref_reserved),
    .test_mode(test_mode), .div_error(div_error)
  );

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(logic b);
    ser_data = b;
    wait_n(HP);
    ser_clk = 1'b1;
    wait_n(HP);
    ser_clk = 1'b0;
  endtask

  task automatic put_word(logic [17:0] w);
    for (int i = 17; i >= 0; i--) put_bit(w[i]);
  endtask

  task automatic strobe();
    wait_n(HP);
    ser_latch = 1'b1;
    wait_n(HP);
    ser_latch = 1'b0;
    wait_n(HP + 4);
  endtask

  task automatic model(logic [17:0] w);
    if (!w[0]) begin
      e_b = w[17:8]; e_a = w[7:3]; e_ctl = w[2:1];
    end else begin
      e_off = w[11]; e_pol = w[12]; e_rsv = w[13]; e_test = w[14];
      if (w[10:1] < 10'd2) e_err = 1'b1;
      else begin e_div = w[10:1]; e_err = 1'b0; end
    end
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, "feedback", {17'd0, fb_b_count, fb_a_count, fb_ctrl}, {17'd0, e_b, e_a, e_ctl});
    check(tag, "reference", {18'd0, test_mode, ref_reserved, pd_polarity, cp_tristate, ref_div},
          {18'd0, e_test, e_rsv, e_pol, e_off, e_div});
    check(tag, "error", {31'd0, div_error}, {31'd0, e_err});
  endtask

  task automatic send(logic [17:0] w, string tag);
    put_word(w);
    strobe();
    model(w);
    check_all(tag);
  endtask

  initial begin
    e_b = '0; e_a = '0; e_ctl = '0; e_div = 10'd2;
    e_off = 0; e_pol = 0; e_rsv = 0; e_test = 0; e_err = 0;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);
    check_all("R1");

    // R5: walking one through every feedback data bit
    for (int k = 1; k < 18; k++) send(18'(1) << k, "R5");
    send(18'h3FFFE, "R5");
    send(18'h2AAAA, "R5");
    send(18'h15554, "R5");

    // R6 / R8: reference divide sweep with rotating control and ignored bits
    for (int d = 0; d < 64; d++) begin
      logic [17:0] w;
      w = {3'(d * 5), 4'(d), 10'(d), 1'b1};
      send(w, (d < 2) ? "R8" : "R6");
    end
    send({3'b111, 4'b1111, 10'd1023, 1'b1}, "R6");
    send({3'b000, 4'b0000, 10'd512, 1'b1}, "R6");

    // R3: feedback load leaves reference untouched
    send({10'h155, 5'h0A, 2'b01, 1'b0}, "R3");
    // R4: reference load leaves feedback untouched
    send({3'b000, 4'b0101, 10'd77, 1'b1}, "R4");

    // R8: error persistence and clearing
    send({3'b000, 4'b1010, 10'd0, 1'b1}, "R8");
    send({10'h0F0, 5'h11, 2'b10, 1'b0}, "R8");
    send({3'b000, 4'b0000, 10'd2, 1'b1}, "R8");

    // R2: leading junk bits are pushed out
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    send({10'h2C3, 5'h1B, 2'b11, 1'b0}, "R2");

    // R7: shifting with strobe high or low does not load
    ser_latch = 1'b1;
    wait_n(2 * HP);
    put_word({10'h3FF, 5'h1F, 2'b11, 1'b0});
    wait_n(2 * HP);
    check_all("R7");
    ser_latch = 1'b0;
    wait_n(2 * HP);
    check_all("R7");
    put_word({10'h001, 5'h02, 2'b01, 1'b0});
    wait_n(2 * HP);
    check_all("R7");
    strobe();
    model({10'h001, 5'h02, 2'b01, 1'b0});
    check_all("R7");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule